// File: doc/BRIEF.md
# Button-stepped hexadecimal counter with segment display

This block keeps a 4-bit count that a person steps by hand with a push button and shows that count as one hexadecimal character on a seven-segment digit. A second push button clears the count to zero. Both buttons are active low and reach the block as raw asynchronous levels. Each button goes through its own flip-flop synchroniser before any logic uses it.

A press of the step button is found as a high-to-low transition of its synchronised level. That transition yields a single one-cycle increment request. Holding the button down therefore advances the count by exactly one, whether it is held for a few cycles or for millions. The clear button acts synchronously once it is synchronised, and it wins over an increment in the same cycle. The count wraps from F to 0. A purely combinational decoder turns the registered count into an active-low segment pattern.

Top module: `hexstep_display`

## Requirements
- R1: While the clear button input is held low, after synchronisation the count is 0 and the segment output reads 7'b1000000 (bit 6 is segment g, bit 0 is segment a, 0 means lit).
- R2: One low period of the step button input advances the count by exactly one, however many clock cycles the button stays low.
- R3: Driving the clear button input low clears the count to 0 through a synchronous path; the count stays 0 while it is held.
- R4: The rising edge of the step button input (release) and a steady level of either button leave the count unchanged.
- R5: When the clear and an increment request fall in the same cycle, the count becomes 0, and a step button that is still held low when the clear is released causes no increment.
- R6: Stepping from count 15 gives count 0.
- R7: The segment output, written bit 6 down to bit 0, is 1000000, 1111001, 0100100, 0110000, 0011001, 0010010, 0000010, 1111000, 0000000, 0010000, 0001000, 0000011, 1000110, 0100001, 0000110, 0001110 for counts 0 to 15 in that order.
- R8: A high-to-low change of the step button input between clock edges appears on the segment output after the third rising clock edge that follows it, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| clr_btn_ni | input | 1 | Clear push button, asynchronous, active low |
| step_btn_ni | input | 1 | Step push button, asynchronous, active low |
| seg_no | output | 7 | Segment drive, active low, bit 0 = a through bit 6 = g |

## Verification
The clear and the increment request can land on the same clock edge. The bench provokes this by lowering both buttons between the same two clock edges, so that both pass through equal synchronisers and meet in one cycle. It keeps the step button low after releasing the clear. The result is judged by the displayed digit, which must read 0 both while the step button is still held and after it is released, with no increment leaking through.

// File: rtl/hexstep_pkg.sv
package hexstep_pkg;
  localparam int unsigned CNT_W = 4;
  localparam int unsigned SEG_W = 7;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef logic [CNT_W-1:0] count_t;
  typedef logic [SEG_W-1:0] seg_t;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  always_comb begin
    ff_d = {ff_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk_i) begin
    ff_q <= ff_d;
  end

  assign sync_o = ff_q[STAGES-1];

  initial begin
    a_stage_count_r8: assert (STAGES >= 2)
      else $error("synchroniser needs two or more stages");
  end
endmodule

// File: rtl/fall_detect.sv
module fall_detect (
  input  logic clk_i,
  input  logic level_i,
  output logic pulse_o
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = level_i;
  end

  always_ff @(posedge clk_i) begin
    prev_q <= prev_d;
  end

  assign pulse_o = prev_q & ~level_i;
endmodule

// File: rtl/step_counter.sv
module step_counter
  import hexstep_pkg::*;
(
  input  logic   clk_i,
  input  logic   clr_i,
  input  logic   inc_i,
  output count_t cnt_o
);
  count_t cnt_q;
  count_t cnt_d;
  logic   cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + count_t'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  p_clear_zero_r3: assert property (@(posedge clk_i) disable iff (1'b0 !== 1'b0)
    clr_i |=> (cnt_q == '0));

  p_step_inc_r2: assert property (@(posedge clk_i) disable iff (clr_i)
    inc_i |=> (cnt_q == count_t'($past(cnt_q) + 1'b1)));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (clr_i)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/hex_seg_decoder.sv
module hex_seg_decoder
  import hexstep_pkg::*;
(
  input  count_t digit_i,
  output seg_t   seg_no
);
  always_comb begin
    unique case (digit_i)
      4'h0: seg_no = 7'b1000000;
      4'h1: seg_no = 7'b1111001;
      4'h2: seg_no = 7'b0100100;
      4'h3: seg_no = 7'b0110000;
      4'h4: seg_no = 7'b0011001;
      4'h5: seg_no = 7'b0010010;
      4'h6: seg_no = 7'b0000010;
      4'h7: seg_no = 7'b1111000;
      4'h8: seg_no = 7'b0000000;
      4'h9: seg_no = 7'b0010000;
      4'hA: seg_no = 7'b0001000;
      4'hB: seg_no = 7'b0000011;
      4'hC: seg_no = 7'b1000110;
      4'hD: seg_no = 7'b0100001;
      4'hE: seg_no = 7'b0000110;
      default: seg_no = 7'b0001110;
    endcase
  end

  always_comb begin
    if (!$isunknown(digit_i)) begin
      a_seg_lit_r7: assert (seg_no != '1)
        else $error("digit pattern is blank");
    end
  end
endmodule

// File: rtl/hexstep_display.sv
module hexstep_display
  import hexstep_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic             clk_i,
  input  logic             clr_btn_ni,
  input  logic             step_btn_ni,
  output logic [SEG_W-1:0] seg_no
);
  logic   clr_sync_n;
  logic   step_sync_n;
  logic   clr_act;
  logic   step_pulse;
  count_t count;

  btn_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk_i   (clk_i),
    .async_i (clr_btn_ni),
    .sync_o  (clr_sync_n)
  );

  btn_sync #(.STAGES(SYNC_STAGES)) u_step_sync (
    .clk_i   (clk_i),
    .async_i (step_btn_ni),
    .sync_o  (step_sync_n)
  );

  assign clr_act = ~clr_sync_n;

  fall_detect u_step_fall (
    .clk_i   (clk_i),
    .level_i (step_sync_n),
    .pulse_o (step_pulse)
  );

  step_counter u_counter (
    .clk_i (clk_i),
    .clr_i (clr_act),
    .inc_i (step_pulse),
    .cnt_o (count)
  );

  hex_seg_decoder u_decoder (
    .digit_i (count),
    .seg_no  (seg_no)
  );

  p_pulse_on_fall_r2: assert property (@(posedge clk_i) disable iff (clr_act)
    step_pulse |-> (!step_sync_n && $past(step_sync_n)));

  p_clear_wins_r5: assert property (@(posedge clk_i) disable iff (1'b0 !== 1'b0)
    (clr_act && step_pulse) |=> (count == '0));
endmodule

// File: tb/test_hexstep_display.sv
module test_hexstep_display;
  logic       clk;
  logic       clr_n;
  logic       step_n;
  logic [6:0] seg;

  int unsigned n_checks;
  int unsigned n_fails;
  int unsigned exp_cnt;
  bit          done;

  hexstep_display i_hexstep_display (
    .clk_i       (clk),
    .clr_btn_ni  (clr_n),
    .step_btn_ni (step_n),
    .seg_no      (seg)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [6:0] seg_of(int unsigned v);
    case (v % 16)
      0:  return 7'b1000000;
      1:  return 7'b1111001;
      2:  return 7'b0100100;
      3:  return 7'b0110000;
      4:  return 7'b0011001;
      5:  return 7'b0010010;
      6:  return 7'b0000010;
      7:  return 7'b1111000;
      8:  return 7'b0000000;
      9:  return 7'b0010000;
      10: return 7'b0001000;
      11: return 7'b0000011;
      12: return 7'b1000110;
      13: return 7'b0100001;
      14: return 7'b0000110;
      default: return 7'b0001110;
    endcase
  endfunction

  task automatic wait_neg(int unsigned n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [6:0] expv);
    n_checks++;
    if (seg !== expv) begin
      n_fails++;
      $display("FAIL %s: seg actual %b expected %b", req, seg, expv);
    end
  endtask

  task automatic press();
    step_n = 1'b0;
    wait_neg(4);
    step_n = 1'b1;
    wait_neg(4);
    exp_cnt = (exp_cnt + 1) % 16;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  // R1: clear held from time zero gives digit 0
  task automatic t_reset();
    wait_neg(6);
    exp_cnt = 0;
    check("R1 reset state", seg_of(0));
    clr_n = 1'b1;
    wait_neg(4);
    check("R1 after clear release", seg_of(0));
  endtask

  // R8 latency, R2 long hold, R4 release
  task automatic t_latency_hold();
    step_n = 1'b0;
    wait_neg(2);
    check("R8 not yet after two edges", seg_of(exp_cnt));
    wait_neg(1);
    exp_cnt = exp_cnt + 1;
    check("R8 visible after third edge", seg_of(exp_cnt));
    wait_neg(40);
    check("R2 long hold single step", seg_of(exp_cnt));
    step_n = 1'b1;
    wait_neg(8);
    check("R4 release has no effect", seg_of(exp_cnt));
  endtask

  // R3 synchronous clear
  task automatic t_clear();
    press();
    press();
    check("R2 two presses", seg_of(exp_cnt));
    clr_n = 1'b0;
    wait_neg(5);
    exp_cnt = 0;
    check("R3 clear while held", seg_of(0));
    clr_n = 1'b1;
    wait_neg(3);
    check("R3 stays zero after release", seg_of(0));
  endtask

  // R6 wrap and R7 every code
  task automatic t_wrap();
    for (int i = 1; i <= 16; i++) begin
      press();
      if (i == 16) check("R6 wrap to zero", seg_of(0));
      else check("R7 segment code", seg_of(i));
    end
  endtask

  // R5 clear and increment in the same cycle
  task automatic t_priority();
    press();
    press();
    press();
    check("R5 precondition count 3", seg_of(3));
    clr_n  = 1'b0;
    step_n = 1'b0;
    wait_neg(6);
    check("R5 clear wins", seg_of(0));
    clr_n = 1'b1;
    wait_neg(8);
    check("R5 held step after clear no step", seg_of(0));
    step_n = 1'b1;
    wait_neg(6);
    exp_cnt = 0;
    check("R5 release after clear no step", seg_of(0));
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    exp_cnt  = 0;
    done     = 1'b0;
    clr_n    = 1'b0;
    step_n   = 1'b1;
    t_reset();
    t_latency_hold();
    t_clear();
    t_wrap();
    t_priority();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not complete");
    report();
  end
endmodule